// File: doc/BRIEF.md
# Keyed Commit Guard for Pin Function Selection

This block holds an eight-bit register that picks, pin by pin, whether a pin carries its alternate function, and it shields that register from stray software writes. The shield has two layers. A lock flop is cleared only by writing one particular 32-bit key to the lock address. While the lock is cleared, software may load a commit mask. Each bit of the mask decides whether the matching bit of the function-select register can change on a later write.

Software uses it in a fixed order. It writes the key, loads a commit mask with ones on the pins it wants to release, writes the function-select register, and then writes any other value to the lock address. The function-select bits leave the block on a port to the pin multiplexer, which is outside this block. All three registers sit on a simple register bus with a write strobe, a read strobe, an address and data. Read data is registered and appears in the cycle after the read strobe.

Top module: `kcp_guard`

## Requirements
- R1: After reset the lock reads as 1 (locked), the commit mask reads as 0xFF and the function-select register reads as 0x00.
- R2: A write of exactly 0x0ACCE551 to offset 0x520 unlocks the block, and the lock register then reads as 0.
- R3: A write of any other 32-bit value to offset 0x520 locks the block, and the lock register then reads as 1. A value that differs from the key in a single bit also locks it.
- R4: While the block is unlocked, a write to offset 0x524 loads bits 7:0 of the write data into the commit mask. Bits 31:8 are dropped, and reads return the mask in bits 7:0 with zeros above.
- R5: While the block is locked, a write to offset 0x524 leaves the commit mask unchanged.
- R6: A write to offset 0x420 changes bit i of the function-select register only where commit mask bit i is 1. Bits whose commit bit is 0 keep their previous value. The lock state has no direct effect on this write.
- R7: An unlock stays in force across any number of commit-mask writes until a non-key value is written to offset 0x520.
- R8: All three registers are readable in either lock state. A read returns data one cycle after the read strobe, and that data is the register value before any write made in the same cycle. An address that matches none of the three offsets exactly reads as 0, and a write to such an address changes nothing.
- R9: The function-select output port always equals the value that reads back from offset 0x420.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_fsel | output | 8 | Per-pin alternate-function select |
| locked | output | 1 | Current lock state |

## Verification
A read and a write can land on the same register in the same cycle. The bench provokes this by raising both strobes in one cycle at offset 0x420 and then at offset 0x524. It judges the first result by requiring the old register contents on the bus, and a second, plain read must then return the newly written value. A full sweep of all 256 commit masks, each followed by a gated write, checks the bit-by-bit merge against arithmetic done in the bench. Single-bit near misses of the key check that the compare covers the full key width.

// File: rtl/kcp_pkg.sv
package kcp_pkg;

   typedef enum logic [1:0] {
      KCP_SEL_NONE   = 2'd0,
      KCP_SEL_FSEL   = 2'd1,
      KCP_SEL_LOCK   = 2'd2,
      KCP_SEL_COMMIT = 2'd3
   } kcp_sel_e;

endpackage

// File: rtl/kcp_decode.sv
module kcp_decode
   import kcp_pkg::*;
#(
   parameter int                ADDR_W       = 12,
   parameter logic [ADDR_W-1:0] FSEL_OFS     = 12'h420,
   parameter logic [ADDR_W-1:0] LOCK_OFS     = 12'h520,
   parameter logic [ADDR_W-1:0] COMMIT_OFS   = 12'h524,
   parameter bit                STRICT_ALIGN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output kcp_sel_e          sel
);

   localparam logic [ADDR_W-1:0] CMP_MASK =
      STRICT_ALIGN ? {ADDR_W{1'b1}} : {{(ADDR_W-2){1'b1}}, 2'b00};

   logic [ADDR_W-1:0] addr_cmp;

   generate
      if (STRICT_ALIGN) begin : g_strict
         assign addr_cmp = addr;
      end else begin : g_word
         assign addr_cmp = addr & CMP_MASK;
      end
   endgenerate

   always_comb begin
      if (addr_cmp == (FSEL_OFS & CMP_MASK))
         sel = KCP_SEL_FSEL;
      else if (addr_cmp == (LOCK_OFS & CMP_MASK))
         sel = KCP_SEL_LOCK;
      else if (addr_cmp == (COMMIT_OFS & CMP_MASK))
         sel = KCP_SEL_COMMIT;
      else
         sel = KCP_SEL_NONE;
   end

endmodule

// File: rtl/kcp_lock.sv
module kcp_lock #(
   parameter int                DATA_W = 32,
   parameter logic [DATA_W-1:0] KEY    = 32'h0ACCE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              locked_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         locked_q <= 1'b1;
      else if (wr)
         locked_q <= (wdata != KEY);
   end

   // R2
   key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata == KEY) |=> !locked_q);

   // R3
   other_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata != KEY) |=> locked_q);

   // R7
   lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(locked_q));

endmodule

// File: rtl/kcp_commit.sv
module kcp_commit #(
   parameter int FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               locked,
   input  logic [FIELD_W-1:0] wdata,
   output logic [FIELD_W-1:0] mask_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= {FIELD_W{1'b1}};
      else if (wr && !locked)
         mask_q <= wdata;
   end

   // R5
   locked_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && locked) |=> $stable(mask_q));

   // R4
   open_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !locked) |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/kcp_field.sv
module kcp_field #(
   parameter int FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [FIELD_W-1:0] mask,
   input  logic [FIELD_W-1:0] wdata,
   output logic [FIELD_W-1:0] field_q
);

   logic [FIELD_W-1:0] field_nxt;

   generate
      for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
         assign field_nxt[i] = (wr && mask[i]) ? wdata[i] : field_q[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         field_q <= '0;
      else
         field_q <= field_nxt;
   end

   // R6
   gated_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (((field_q ^ $past(field_q)) & ~$past(mask)) == '0));

   // R6
   idle_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(field_q));

endmodule

// File: rtl/kcp_guard.sv
module kcp_guard
   import kcp_pkg::*;
#(
   parameter int                ADDR_W       = 12,
   parameter int                DATA_W       = 32,
   parameter int                FIELD_W      = 8,
   parameter logic [ADDR_W-1:0] FSEL_OFS     = 12'h420,
   parameter logic [ADDR_W-1:0] LOCK_OFS     = 12'h520,
   parameter logic [ADDR_W-1:0] COMMIT_OFS   = 12'h524,
   parameter logic [DATA_W-1:0] KEY          = 32'h0ACCE551,
   parameter bit                STRICT_ALIGN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic               bus_re,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [FIELD_W-1:0] pin_fsel,
   output logic               locked
);

   localparam int PAD_W = DATA_W - FIELD_W;

   generate
      if (FIELD_W < 1 || FIELD_W > DATA_W) begin : g_bad_field
         $error("kcp_guard: FIELD_W must lie in 1..DATA_W");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("kcp_guard: ADDR_W too small");
      end
      if (FSEL_OFS == LOCK_OFS || FSEL_OFS == COMMIT_OFS || LOCK_OFS == COMMIT_OFS) begin : g_bad_ofs
         $error("kcp_guard: register offsets must differ");
      end
   endgenerate

   kcp_sel_e           sel;
   logic [FIELD_W-1:0] mask_q;
   logic [FIELD_W-1:0] fsel_q;
   logic [DATA_W-1:0]  rd_mux;

   kcp_decode #(
      .ADDR_W       (ADDR_W),
      .FSEL_OFS     (FSEL_OFS),
      .LOCK_OFS     (LOCK_OFS),
      .COMMIT_OFS   (COMMIT_OFS),
      .STRICT_ALIGN (STRICT_ALIGN)
   ) u_decode (
      .addr (bus_addr),
      .sel  (sel)
   );

   kcp_lock #(
      .DATA_W (DATA_W),
      .KEY    (KEY)
   ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_we && sel == KCP_SEL_LOCK),
      .wdata    (bus_wdata),
      .locked_q (locked)
   );

   kcp_commit #(
      .FIELD_W (FIELD_W)
   ) u_commit (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_we && sel == KCP_SEL_COMMIT),
      .locked (locked),
      .wdata  (bus_wdata[FIELD_W-1:0]),
      .mask_q (mask_q)
   );

   kcp_field #(
      .FIELD_W (FIELD_W)
   ) u_field (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_we && sel == KCP_SEL_FSEL),
      .mask    (mask_q),
      .wdata   (bus_wdata[FIELD_W-1:0]),
      .field_q (fsel_q)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         always_comb begin
            unique case (sel)
               KCP_SEL_FSEL:   rd_mux = {{PAD_W{1'b0}}, fsel_q};
               KCP_SEL_COMMIT: rd_mux = {{PAD_W{1'b0}}, mask_q};
               KCP_SEL_LOCK:   rd_mux = {{(DATA_W-1){1'b0}}, locked};
               default:        rd_mux = '0;
            endcase
         end
      end else begin : g_nopad
         always_comb begin
            unique case (sel)
               KCP_SEL_FSEL:   rd_mux = fsel_q;
               KCP_SEL_COMMIT: rd_mux = mask_q;
               KCP_SEL_LOCK:   rd_mux = {{(DATA_W-1){1'b0}}, locked};
               default:        rd_mux = '0;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_re)
         bus_rdata <= rd_mux;
   end

   assign pin_fsel = fsel_q;

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata));

   // R8
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && sel == KCP_SEL_NONE) |=> (bus_rdata == '0));

endmodule

// File: tb/kcp_guard_bench.sv
`timescale 1ns/1ps
module kcp_guard_bench;

   localparam logic [11:0] A_FSEL   = 12'h420;
   localparam logic [11:0] A_LOCK   = 12'h520;
   localparam logic [11:0] A_COMMIT = 12'h524;
   localparam logic [31:0] KEYV     = 32'h0ACCE551;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_fsel;
   logic        locked;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [7:0] m_fsel;
   logic [7:0] m_mask;
   logic       m_lock;

   always #4 clk = ~clk;

   kcp_guard u_kcp_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_fsel  (pin_fsel),
      .locked    (locked)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_re = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_fsel = 8'h00; m_mask = 8'hFF; m_lock = 1'b1;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] v;
      bus_read(A_LOCK, v);   check({tag, " lock"}, v, {31'd0, m_lock});
      bus_read(A_COMMIT, v); check({tag, " commit"}, v, {24'd0, m_mask});
      bus_read(A_FSEL, v);   check({tag, " fsel"}, v, {24'd0, m_fsel});
      check({tag, " R9 pin_fsel"}, {24'd0, pin_fsel}, {24'd0, m_fsel});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  val;
      do_reset();

      // R1 reset state
      check_all("R1 reset");
      check("R1 locked port", {31'd0, locked}, 32'd1);

      // R5 commit write while locked is ignored
      bus_write(A_COMMIT, 32'h0000_0000);
      bus_read(A_COMMIT, v); check("R5 locked commit", v, 32'h0000_00FF);

      // R6 full mask after reset lets every bit through
      bus_write(A_FSEL, 32'hFFFF_FFA5); m_fsel = 8'hA5;
      check_all("R6 open mask");

      // R3 single-bit near misses of the key all lock
      for (int b = 0; b < 32; b++) begin
         bus_write(A_LOCK, KEYV);
         bus_write(A_LOCK, KEYV ^ (32'd1 << b));
         bus_read(A_LOCK, v); check("R3 near-miss lock", v, 32'd1);
         bus_write(A_COMMIT, 32'h0000_0000);
         bus_read(A_COMMIT, v); check("R5 commit after near-miss", v, 32'h0000_00FF);
      end

      // R2 key unlocks
      bus_write(A_LOCK, KEYV); m_lock = 1'b0;
      bus_read(A_LOCK, v); check("R2 unlock", v, 32'd0);

      // R4 R6 R7 sweep of every commit mask
      for (int m = 0; m < 256; m++) begin
         bus_write(A_COMMIT, 32'hDEAD_BE00 | 32'(m)); m_mask = 8'(m);
         bus_read(A_COMMIT, v); check("R4 commit load", v, {24'd0, m_mask});
         val = 8'((m * 37 + 11) ^ 8'h5A);
         bus_write(A_FSEL, {24'hFFFFFF, val});
         m_fsel = (m_fsel & ~m_mask) | (val & m_mask);
         bus_read(A_FSEL, v); check("R6 gated write", v, {24'd0, m_fsel});
         check("R9 pin_fsel", {24'd0, pin_fsel}, {24'd0, m_fsel});
         if (m % 32 == 31) begin
            bus_read(A_LOCK, v); check("R7 stays unlocked", v, 32'd0);
         end
      end

      // R8 same-cycle read and write of the function-select register
      bus_write(A_COMMIT, 32'h0000_00FF); m_mask = 8'hFF;
      bus_write(A_FSEL, 32'h0000_003C); m_fsel = 8'h3C;
      @(negedge clk);
      bus_we = 1'b1; bus_re = 1'b1; bus_addr = A_FSEL; bus_wdata = 32'h0000_00C3;
      @(negedge clk);
      bus_we = 1'b0; bus_re = 1'b0;
      check("R8 same-cycle fsel old value", bus_rdata, 32'h0000_003C);
      m_fsel = 8'hC3;
      bus_read(A_FSEL, v); check("R8 fsel new value", v, 32'h0000_00C3);

      // R8 same-cycle read and write of the commit mask
      @(negedge clk);
      bus_we = 1'b1; bus_re = 1'b1; bus_addr = A_COMMIT; bus_wdata = 32'h0000_000F;
      @(negedge clk);
      bus_we = 1'b0; bus_re = 1'b0;
      check("R8 same-cycle commit old value", bus_rdata, 32'h0000_00FF);
      m_mask = 8'h0F;
      bus_read(A_COMMIT, v); check("R8 commit new value", v, 32'h0000_000F);

      // R3 relock with zero, R8 registers still readable
      bus_write(A_LOCK, 32'h0000_0000); m_lock = 1'b1;
      check_all("R8 locked readback");

      // R6 lock state does not gate the function-select write itself
      bus_write(A_FSEL, 32'h0000_0000);
      m_fsel = m_fsel & ~m_mask;
      check_all("R6 write while locked");

      // R5 commit still frozen
      bus_write(A_COMMIT, 32'h0000_00FF);
      check_all("R5 frozen mask");

      // R8 unmapped and misaligned addresses
      bus_read(12'h421, v); check("R8 misaligned read", v, 32'd0);
      bus_read(12'h528, v); check("R8 unmapped read", v, 32'd0);
      bus_write(12'h422, 32'h0000_00FF);
      bus_write(12'h521, KEYV);
      check_all("R8 unmapped write");

      // R1 reset again after activity
      do_reset();
      check_all("R1 second reset");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule